// File: doc/BRIEF.md
# Free-Running Interval Timer with Selectable Prescaler

This block is an 8-bit up-counter that cannot be stopped. It advances once for each enable pulse from a prescaler. The prescaler is a free-running binary divider on the oscillator clock. A 3-bit select field picks one of eight power-of-two divisions, from eight up to 1024 oscillator cycles per count. When the counter wraps from its top value to zero, the block sets an interrupt request flag. That flag stays set until the CPU acknowledges it. A one-cycle wrap strobe and the live count are also sent to a watchdog.

The CPU sees a single address with two meanings. A read returns the live count. A write loads a write-only control byte, which cannot be read back. The control byte holds the prescaler select and a restart bit. The restart bit zeroes the counter and clears itself one cycle later. The control byte also holds three mode bits. These are passed to the power manager and the watchdog on their own pins and do not affect counting.

Top module: `ivTimer`

## Requirements
- R1: After reset the count is 0, `irqFlag` is 0, `wakeEn` and `rcWdtEn` are 0, `wdtOn` is 1, and the prescaler select is 7 (one count per 1024 clocks).
- R2: The count increases by exactly one, wrapping from 255 to 0, on each prescaler pulse, and holds between pulses; no control value stops it.
- R3: Written data bits 2:0 select the division: value s gives one prescaler pulse every 2^(s+3) clocks, so 0 is 8 clocks and 7 is 1024 clocks.
- R4: On the wrap from 255 to 0, `irqFlag` becomes 1 and `wdtOvf` is high for exactly the one cycle in which the count first reads 0.
- R5: `irqFlag` stays 1 until a cycle with `irqAck` high and then reads 0 on the next cycle, unless a wrap happens in that same cycle, in which case it stays 1.
- R6: A write with data bit 3 set makes the count read 0 on the next cycle, even if a prescaler pulse falls in the same cycle. The restart bit then clears itself after one cycle, so counting resumes from 0.
- R7: `rdData` equals the live count while `rdEn` is high and is 0 otherwise; the control byte is never returned.
- R8: Written data bits 6, 5 and 4 appear on `wakeEn`, `rcWdtEn` and `wdtOn` from the cycle after the write; bit 7 is ignored, and none of these bits changes the count.
- R9: `wdtCount` always equals the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | CPU read strobe for the shared address |
| rdData | output | 8 | Live count while reading, else 0 |
| wrEn | input | 1 | CPU write strobe for the shared address |
| wrData | input | 8 | Control byte written by the CPU |
| irqFlag | output | 1 | Wrap interrupt request |
| irqAck | input | 1 | Interrupt acknowledge |
| wdtCount | output | 8 | Live count to the watchdog |
| wdtOvf | output | 1 | One-cycle wrap strobe to the watchdog |
| wakeEn | output | 1 | Wake-up timer mode bit |
| rcWdtEn | output | 1 | RC watchdog mode bit |
| wdtOn | output | 1 | Watchdog enable, 0 selects plain timer use |

## Verification
Every one of the eight select values is written together with a restart. The count is then tracked against a cycle-by-cycle model. For each select, a window of three pulse periods must advance the count by exactly three, which separates each division from its neighbours. For the five fastest selects, the run continues through a full wrap so that the flag and the strobe appear. Collision patterns are then forced: an acknowledge in the very cycle of a wrap, and a restart in the very cycle of a prescaler pulse. These show the set-over-acknowledge priority and the restart-over-count priority. The writes use changing mode bits and a set bit 7, and the read strobe is toggled, to show that the mode pins are independent of the count and that reads are gated.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 3;
  localparam int CLR_BIT  = 3;
  localparam int WDT_BIT  = 4;
  localparam int RC_BIT   = 5;
  localparam int WAKE_BIT = 6;
  localparam logic [SEL_W-1:0] SEL_RESET = '1;

  typedef struct packed {
    logic tick;
    logic clr;
    logic ack;
  } ivtStrobe_t;
endpackage

// File: rtl/ivtControl.sv
module ivtControl
  import ivt_pkg::*;
#(
  parameter int MIN_LOG = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqAck,
  output ivtStrobe_t        strobe,
  output logic              wakeEn,
  output logic              rcWdtEn,
  output logic              wdtOn
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int DIV_W = MIN_LOG + NSEL - 1;

  logic [DIV_W-1:0] divCnt;
  logic [SEL_W-1:0] selReg;
  logic [NSEL-1:0]  tickVec;
  logic             clrBit;
  logic             clrReq;
  logic             unusedBit7;

  assign unusedBit7 = wrData[7];
  assign clrReq     = wrEn & wrData[CLR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    assign tickVec[i] = &divCnt[MIN_LOG+i-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= SEL_RESET;
      wakeEn  <= 1'b0;
      rcWdtEn <= 1'b0;
      wdtOn   <= 1'b1;
      clrBit  <= 1'b0;
    end else begin
      clrBit <= clrReq;
      if (wrEn) begin
        selReg  <= wrData[SEL_W-1:0];
        wakeEn  <= wrData[WAKE_BIT];
        rcWdtEn <= wrData[RC_BIT];
        wdtOn   <= wrData[WDT_BIT];
      end
    end
  end

  always_comb begin
    strobe.tick = tickVec[selReg];
    strobe.clr  = clrReq;
    strobe.ack  = irqAck;
  end

  assert_clr_selfclear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrBit && !clrReq) |=> !clrBit);
  assert_tick_isolated_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> !strobe.tick);
endmodule

// File: rtl/ivtDatapath.sv
module ivtDatapath
  import ivt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ivtStrobe_t       strobe,
  output logic [CNT_W-1:0] count,
  output logic             ovfPulse,
  output logic             irqFlag
);
  logic ovfNow;

  assign ovfNow = strobe.tick & ~strobe.clr & (&count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      ovfPulse <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      if (strobe.clr)       count <= '0;
      else if (strobe.tick) count <= count + 1'b1;
      ovfPulse <= ovfNow;
      irqFlag  <= ovfNow | (irqFlag & ~strobe.ack);
    end
  end

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (count == '0));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clr && !strobe.tick) |=> $stable(count));
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clr && strobe.tick) |=> (count == $past(count) + 1'b1));
  assert_ovf_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (count == '0 && irqFlag));
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !strobe.ack) |=> irqFlag);
endmodule

// File: rtl/ivTimer.sv
module ivTimer
  import ivt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MIN_LOG = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  output logic [CNT_W-1:0]  rdData,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              irqFlag,
  input  logic              irqAck,
  output logic [CNT_W-1:0]  wdtCount,
  output logic              wdtOvf,
  output logic              wakeEn,
  output logic              rcWdtEn,
  output logic              wdtOn
);
  ivtStrobe_t       strobe;
  logic [CNT_W-1:0] count;

  ivtControl #(.MIN_LOG(MIN_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .irqAck(irqAck),
    .strobe(strobe), .wakeEn(wakeEn), .rcWdtEn(rcWdtEn), .wdtOn(wdtOn)
  );

  ivtDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .count(count), .ovfPulse(wdtOvf), .irqFlag(irqFlag)
  );

  assign rdData   = rdEn ? count : '0;
  assign wdtCount = count;
endmodule

// File: tb/ivTimer_test.sv
module ivTimer_test;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b1;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic irqAck = 1'b0;
  logic [7:0] rdData, wdtCount;
  logic irqFlag, wdtOvf, wakeEn, rcWdtEn, wdtOn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [9:0] refDiv;
  logic [7:0] refCnt;
  logic [2:0] refSel;
  logic refFlag, refOvf, refWake, refRc, refWdt;
  logic tk, cl, ov;

  always #(CLK_PER/2) clk = ~clk;

  ivTimer uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdData(rdData), .wrEn(wrEn),
    .wrData(wrData), .irqFlag(irqFlag), .irqAck(irqAck), .wdtCount(wdtCount),
    .wdtOvf(wdtOvf), .wakeEn(wakeEn), .rcWdtEn(rcWdtEn), .wdtOn(wdtOn)
  );

  function automatic logic [9:0] maskOf(input logic [2:0] s);
    return 10'((1 << (int'(s) + 3)) - 1);
  endfunction

  function automatic bit nextTick();
    return (refDiv & maskOf(refSel)) == maskOf(refSel);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refDiv <= '0; refCnt <= '0; refSel <= 3'd7; refFlag <= 1'b0; refOvf <= 1'b0;
      refWake <= 1'b0; refRc <= 1'b0; refWdt <= 1'b1;
    end else begin
      tk = (refDiv & maskOf(refSel)) == maskOf(refSel);
      cl = wrEn && wrData[3];
      ov = tk && !cl && (refCnt == 8'hFF);
      refDiv <= refDiv + 1'b1;
      refCnt <= cl ? 8'd0 : (tk ? refCnt + 1'b1 : refCnt);
      refOvf <= ov;
      refFlag <= ov | (refFlag & ~irqAck);
      if (wrEn) begin
        refSel <= wrData[2:0]; refWake <= wrData[6]; refRc <= wrData[5]; refWdt <= wrData[4];
      end
    end
  end

  // per-cycle comparison, sampled a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_PER/4);
    if (rstN && !done) begin
      check(wdtCount == refCnt, "R2/R3 count", wdtCount, refCnt);
      check(wdtCount == rdData || !rdEn, "R9 wdtCount", wdtCount, rdData);
      check(rdData == (rdEn ? refCnt : 8'd0), "R7 rdData", rdData, rdEn ? refCnt : 0);
      check(irqFlag == refFlag, "R5 irqFlag", irqFlag, refFlag);
      check(wdtOvf == refOvf, "R4 wdtOvf", wdtOvf, refOvf);
      check({wakeEn, rcWdtEn, wdtOn} == {refWake, refRc, refWdt}, "R8 mode pins",
            {wakeEn, rcWdtEn, wdtOn}, {refWake, refRc, refWdt});
    end
  end

  task automatic writeCtrl(input logic [7:0] v);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    #(CLK_PER * 190000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wdtCount == 0, "R1 count at reset", wdtCount, 0);
    check(irqFlag == 0, "R1 flag at reset", irqFlag, 0);
    check({wakeEn, rcWdtEn, wdtOn} == 3'b001, "R1 mode pins at reset",
          {wakeEn, rcWdtEn, wdtOn}, 1);
    rstN = 1'b1;
    repeat (1030) @(negedge clk);
    check(wdtCount == 1, "R1 default divide by 1024", wdtCount, 1);

    for (int s = 0; s < 8; s++) begin
      int per;
      int startCnt;
      per = 8 << s;
      writeCtrl({1'b1, 3'(s ^ 5), 1'b1, 3'(s)});
      check({wakeEn, rcWdtEn, wdtOn} == 3'(s ^ 5), "R8 mode bits follow write",
            {wakeEn, rcWdtEn, wdtOn}, s ^ 5);
      startCnt = wdtCount;
      repeat (3 * per) @(negedge clk);
      check(wdtCount - startCnt == 3, "R3 three periods give three counts",
            wdtCount - startCnt, 3);
      if (s <= 4) begin
        repeat (256 * per) @(negedge clk);
        check(irqFlag == 1, "R4 wrap sets flag", irqFlag, 1);
        irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
        check(irqFlag == 0, "R5 ack clears flag", irqFlag, 0);
      end
    end

    // fastest division for collision patterns
    writeCtrl(8'h08);
    repeat (256 * 8 + 20) @(negedge clk);
    check(irqFlag == 1, "R5 flag held without ack", irqFlag, 1);
    while (!(refCnt == 8'hFF && nextTick())) @(negedge clk);
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
    check(irqFlag == 1 && wdtOvf == 1, "R5 wrap beats same-cycle ack",
          {irqFlag, wdtOvf}, 3);
    @(negedge clk);
    check(wdtOvf == 0, "R4 strobe is one cycle", wdtOvf, 0);

    repeat (40) @(negedge clk);
    while (!nextTick()) @(negedge clk);
    writeCtrl(8'h00 | 8'h08);
    check(wdtCount == 0, "R6 clear beats same-cycle tick", wdtCount, 0);
    repeat (16) @(negedge clk);
    check(wdtCount == 2, "R6 counting resumes after clear", wdtCount, 2);

    rdEn = 1'b0;
    repeat (30) @(negedge clk);
    check(rdData == 0, "R7 no read returns 0", rdData, 0);
    writeCtrl(8'hF0);
    check(rdData == 0, "R7 control byte not returned", rdData, 0);
    rdEn = 1'b1;
    repeat (30) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule